// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on clocks with no fixed relation to each other. Storage depth is a power of two set by a parameter. Four active-low status flags report the fill level:
- Empty and almost-empty are produced in the read clock domain.
- Full and almost-full are produced in the write clock domain.

Each domain sees the other side's pointer only through a Gray-coded, two-stage synchronizer.

One shared input has two roles, chosen by its level while reset is held:
- **Second write enable.** If the input is high during reset, it acts as an extra write enable.
- **Offset load and read-back control.** If the input is low during reset, it controls the loading and read-back of the two threshold offsets.

Each offset is held as a low word and a high word. The four offset words are written, and read back, in a fixed rotation.

The block uses active-low enables and flags, not a valid/ready handshake. Back-pressure on the write side is the full flag: a write attempted while full is low is dropped. On the read side, a read attempted while empty is low is dropped. The output register drives the data port only while the output enable is low. When the output enable is high, the port models high impedance by reading zero, with its drive indicator low.

Top module: `pflag_fifo`

## Requirements
- R1: A clock edge of a domain with `rst_n` low clears that domain's pointer and resets its flags and offsets. After reset, `full_n`=1, `afull_n`=1, `empty_n`=0, `aempty_n`=0, `q`=0. Both offsets return to 7, held as words 7,0,7,0 in slot order.
- R2: The level of `wen2_ld` during reset selects the mode. High selects two-enable mode. Low selects offset-program mode, in which `wen2_ld` low turns `wen1_n` low into an offset load rather than a data write.
- R3: A word on `din` is stored on a `wclk` rising edge when `wen1_n`=0 and `wen2_ld`=1, in either mode. In two-enable mode, `wen1_n`=0 with `wen2_ld`=0 stores nothing.
- R4: A write while `full_n`=0 is dropped and never appears at the output. A read while `empty_n`=0 is dropped and leaves `q` unchanged.
- R5: A read needs `ren1_n`=0 and `ren2_n`=0 on an `rclk` rising edge (and `wen2_ld`=1 in program mode). The oldest word appears on `q` right after that edge. If only one read enable is low, nothing is read.
- R6: With default offsets, `aempty_n`=0 while the stored count is 7 or less. `afull_n`=0 while the count is DEPTH-7 or more.
- R7: `full_n`=0 exactly when the count is DEPTH, and `empty_n`=0 exactly when the count is 0. Each flag settles within a few cycles of its own clock after the far side stops.
- R8: Pointers cross domains in Gray code, so the synchronized read pointer seen by the write side changes by at most one bit per `wclk` edge. Data crosses intact under concurrent writing and reading.
- R9: `oe_n`=1 forces `q`=0 and `q_drv`=0. `oe_n`=0 sets `q_drv`=1 and shows the output register.
- R10: In program mode, each `wclk` edge with `wen1_n`=0 and `wen2_ld`=0 stores `din` into the next offset slot, in the order: slot0 almost-empty low word, slot1 almost-empty high word, slot2 almost-full low word, slot3 almost-full high word. After slot3 the order wraps to slot0. Loads leave the FIFO contents alone.
- R11: In program mode, each `rclk` edge with both read enables low and `wen2_ld`=0 puts the next offset slot on `q`, in the same rotation and without consuming data. The rotation restarts at slot0 on reset.
- R12: Loaded offsets move the thresholds. `aempty_n`=0 while the count is at most {slot1,slot0}. `afull_n`=0 while the count is at least DEPTH-{slot3,slot2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in both domains |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable, or load/read-back control (mode set at reset) |
| din | input | DW | Write data or offset word |
| ren1_n | input | 1 | Active-low read enable 1 |
| ren2_n | input | 1 | Active-low read enable 2 |
| oe_n | input | 1 | Active-low output enable |
| q | output | DW | Read data or offset word; zero while disabled |
| q_drv | output | 1 | High while the output is driven |
| empty_n | output | 1 | Low when empty (read domain) |
| aempty_n | output | 1 | Low when at or below the almost-empty threshold (read domain) |
| afull_n | output | 1 | Low when at or above the almost-full threshold (write domain) |
| full_n | output | 1 | Low when full (write domain) |

## Verification
The assertions assume four things about the stimulus:
- The write clock runs at least as fast as the read clock. This is what lets the synchronized read pointer move by at most one Gray step per write edge.
- Inputs change only away from the edges of the clock that samples them.
- Offsets are reloaded only while no data traffic is flowing.
- Reset is held across several edges of both clocks.

The bench keeps to these assumptions:
- It runs the write clock at 10 ns and the read clock at 13 ns.
- It drives each side on the falling edge of that side's clock.
- It holds reset for several read-clock cycles.
- It toggles the shared load pin only while both enable groups are idle.

// File: rtl/pflag_fifo_pkg.sv
`timescale 1ns/100ps
package pflag_fifo_pkg;

  typedef enum logic {
    MODE_PROG   = 1'b0,
    MODE_TWO_EN = 1'b1
  } fifo_mode_e;

  localparam int unsigned DEFAULT_OFS = 7;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/pflag_fifo_sync.sv
`timescale 1ns/100ps
module pflag_fifo_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/pflag_fifo_ram.sv
`timescale 1ns/100ps
module pflag_fifo_ram #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pflag_fifo_wside.sv
`timescale 1ns/100ps
module pflag_fifo_wside
  import pflag_fifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic            wclk,
  input  logic            rst_n,
  input  logic            wen1_n,
  input  logic            wen2_ld,
  input  logic [DW-1:0]   din,
  input  logic [AW:0]     rgray_s,
  output logic            mem_we,
  output logic [AW-1:0]   waddr,
  output logic [AW:0]     wbin,
  output logic [AW:0]     wgray,
  output logic            full_n,
  output logic            afull_n,
  output logic            two_en,
  output logic [AW-1:0]   pae_ofs,
  output logic [4*DW-1:0] slot_flat
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  fifo_mode_e     mode_q;
  logic [PW-1:0]  wbin_q, wgray_q, wbin_nx, rbin_s, used_nx, afull_lim;
  logic           full_n_q, afull_n_q;
  logic           wr_req, ld_req, do_wr;
  logic [DW-1:0]  slot_q [4];
  logic [1:0]     lptr_q;
  logic [2*DW-1:0] pae_pair, paf_pair;

  assign two_en  = (mode_q == MODE_TWO_EN);
  assign wr_req  = !wen1_n && wen2_ld;
  assign ld_req  = !two_en && !wen1_n && !wen2_ld;
  assign do_wr   = wr_req && full_n_q;

  assign rbin_s  = PW'(from_gray(32'(rgray_s)));
  assign wbin_nx = wbin_q + PW'(do_wr);
  assign used_nx = wbin_nx - rbin_s;

  assign pae_pair  = {slot_q[1], slot_q[0]};
  assign paf_pair  = {slot_q[3], slot_q[2]};
  assign afull_lim = PW'(DEPTH) - {1'b0, paf_pair[AW-1:0]};

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      mode_q    <= fifo_mode_e'(wen2_ld);
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wbin_q    <= wbin_nx;
      wgray_q   <= PW'(to_gray(32'(wbin_nx)));
      full_n_q  <= (used_nx != PW'(DEPTH));
      afull_n_q <= (used_nx < afull_lim);
    end
  end

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      slot_q[0] <= DW'(DEFAULT_OFS);
      slot_q[1] <= '0;
      slot_q[2] <= DW'(DEFAULT_OFS);
      slot_q[3] <= '0;
      lptr_q    <= '0;
    end else if (ld_req) begin
      slot_q[lptr_q] <= din;
      lptr_q         <= lptr_q + 2'd1;
    end
  end

  assign mem_we    = do_wr;
  assign waddr     = wbin_q[AW-1:0];
  assign wbin      = wbin_q;
  assign wgray     = wgray_q;
  assign full_n    = full_n_q;
  assign afull_n   = afull_n_q;
  assign pae_ofs   = pae_pair[AW-1:0];
  assign slot_flat = {slot_q[3], slot_q[2], slot_q[1], slot_q[0]};
endmodule

// File: rtl/pflag_fifo_rside.sv
`timescale 1ns/100ps
module pflag_fifo_rside
  import pflag_fifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic            rclk,
  input  logic            rst_n,
  input  logic            ren1_n,
  input  logic            ren2_n,
  input  logic            wen2_ld,
  input  logic [AW:0]     wgray_s,
  input  logic [DW-1:0]   rdata,
  input  logic [4*DW-1:0] slot_flat,
  input  logic [AW-1:0]   pae_ofs,
  output logic [AW-1:0]   raddr,
  output logic [AW:0]     rbin,
  output logic [AW:0]     rgray,
  output logic            empty_n,
  output logic            aempty_n,
  output logic            two_en,
  output logic [DW-1:0]   q_reg
);
  localparam int PW = AW + 1;

  fifo_mode_e    mode_q;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, wbin_s, used_nx;
  logic          empty_n_q, aempty_n_q;
  logic          both_en, rd_req, rb_req, do_rd;
  logic [1:0]    rptr_q;
  logic [DW-1:0] q_q;

  assign two_en  = (mode_q == MODE_TWO_EN);
  assign both_en = !ren1_n && !ren2_n;
  assign rd_req  = both_en && (two_en || wen2_ld);
  assign rb_req  = both_en && !two_en && !wen2_ld;
  assign do_rd   = rd_req && empty_n_q;

  assign wbin_s  = PW'(from_gray(32'(wgray_s)));
  assign rbin_nx = rbin_q + PW'(do_rd);
  assign used_nx = wbin_s - rbin_nx;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      mode_q     <= fifo_mode_e'(wen2_ld);
      rbin_q     <= '0;
      rgray_q    <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rbin_q     <= rbin_nx;
      rgray_q    <= PW'(to_gray(32'(rbin_nx)));
      empty_n_q  <= (used_nx != '0);
      aempty_n_q <= (used_nx > {1'b0, pae_ofs});
    end
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      q_q    <= '0;
      rptr_q <= '0;
    end else if (do_rd) begin
      q_q <= rdata;
    end else if (rb_req) begin
      q_q    <= slot_flat[rptr_q*DW +: DW];
      rptr_q <= rptr_q + 2'd1;
    end
  end

  assign raddr    = rbin_q[AW-1:0];
  assign rbin     = rbin_q;
  assign rgray    = rgray_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;
  assign q_reg    = q_q;
endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/100ps
module pflag_fifo #(
  parameter int DW = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic [DW-1:0] din,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] q,
  output logic          q_drv,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          afull_n,
  output logic          full_n
);
  localparam int PW = AW + 1;

  logic            mem_we;
  logic [AW-1:0]   waddr, raddr;
  logic [DW-1:0]   rdata, q_reg;
  logic [PW-1:0]   w_bin, w_gray, r_bin, r_gray;
  logic [PW-1:0]   wgray_r, rgray_w;
  logic            two_en_w, two_en_r;
  logic [AW-1:0]   pae_ofs;
  logic [4*DW-1:0] slot_flat;

  pflag_fifo_wside #(.DW(DW), .AW(AW)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
    .rgray_s(rgray_w), .mem_we(mem_we), .waddr(waddr), .wbin(w_bin),
    .wgray(w_gray), .full_n(full_n), .afull_n(afull_n), .two_en(two_en_w),
    .pae_ofs(pae_ofs), .slot_flat(slot_flat)
  );

  pflag_fifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(rdata)
  );

  pflag_fifo_sync #(.W(PW)) u_sync_w2r (
    .clk(rclk), .rst_n(rst_n), .d(w_gray), .q(wgray_r)
  );

  pflag_fifo_sync #(.W(PW)) u_sync_r2w (
    .clk(wclk), .rst_n(rst_n), .d(r_gray), .q(rgray_w)
  );

  pflag_fifo_rside #(.DW(DW), .AW(AW)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n),
    .wen2_ld(wen2_ld), .wgray_s(wgray_r), .rdata(rdata), .slot_flat(slot_flat),
    .pae_ofs(pae_ofs), .raddr(raddr), .rbin(r_bin), .rgray(r_gray),
    .empty_n(empty_n), .aempty_n(aempty_n), .two_en(two_en_r), .q_reg(q_reg)
  );

  assign q     = oe_n ? '0 : q_reg;
  assign q_drv = !oe_n;
endmodule

// File: rtl/pflag_fifo_chk.sv
`timescale 1ns/100ps
module pflag_fifo_chk
  import pflag_fifo_pkg::*;
#(
  parameter int AW = 6
) (
  input logic        wclk,
  input logic        rclk,
  input logic        rst_n,
  input logic        wen1_n,
  input logic        wen2_ld,
  input logic        ren1_n,
  input logic        ren2_n,
  input logic        full_n,
  input logic        empty_n,
  input logic        two_en_w,
  input logic        two_en_r,
  input logic [AW:0] w_bin,
  input logic [AW:0] r_bin,
  input logic [AW:0] rgray_w
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin_w, used_w;
  assign rbin_w = PW'(from_gray(32'(rgray_w)));
  assign used_w = w_bin - rbin_w;

  // R3: an enabled write with room advances the write pointer by one
  p_write_step_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (!wen1_n && wen2_ld && full_n) |=> (w_bin == $past(w_bin) + PW'(1)));

  // R4: no write pointer movement while full
  p_no_overflow_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(w_bin));

  // R4: no read pointer movement while empty
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(r_bin));

  // R5: an enabled read with data advances the read pointer by one
  p_read_step_r5: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ren1_n && !ren2_n && (two_en_r || wen2_ld) && empty_n)
      |=> (r_bin == $past(r_bin) + PW'(1)));

  // R7: the write side never sees more than DEPTH entries
  p_count_bound_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    used_w <= PW'(DEPTH));

  // R8: synchronized read pointer moves by at most one Gray step
  p_gray_step_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(rgray_w ^ $past(rgray_w)) <= 1);

  // R10: an offset load does not store data
  p_load_hold_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    (!two_en_w && !wen1_n && !wen2_ld) |=> $stable(w_bin));

  // R11: an offset read-back does not consume data
  p_readback_hold_r11: assert property (@(posedge rclk) disable iff (!rst_n)
    (!two_en_r && !ren1_n && !ren2_n && !wen2_ld) |=> $stable(r_bin));
endmodule

bind pflag_fifo pflag_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .full_n(full_n), .empty_n(empty_n),
  .two_en_w(two_en_w), .two_en_r(two_en_r), .w_bin(w_bin), .r_bin(r_bin),
  .rgray_w(rgray_w)
);

// File: tb/sim_pflag_fifo.sv
`timescale 1ns/100ps
module sim_pflag_fifo;
  localparam int DW    = 9;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, wen1_n = 1'b1, wen2_ld = 1'b1;
  logic ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] q;
  logic q_drv, empty_n, aempty_n, afull_n, full_n;

  int n_chk = 0, n_err = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] last_rd = '0;
  bit tb_two = 1'b1;
  bit wr_busy = 1'b0;
  bit done = 1'b0;
  int pae_m = 7, paf_m = 7;

  always #5   wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  pflag_fifo #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q(q),
    .q_drv(q_drv), .empty_n(empty_n), .aempty_n(aempty_n), .afull_n(afull_n),
    .full_n(full_n)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // scoreboard monitor: every accepted data read pops one expected word
  always @(posedge rclk) begin
    if (rst_n === 1'b1 && ren1_n === 1'b0 && ren2_n === 1'b0 &&
        empty_n === 1'b1 && (tb_two || wen2_ld === 1'b1)) begin
      #2;
      if (sb.size() == 0) begin
        chk_eq("R4 read with empty model", 1, 0);
      end else begin
        last_rd = sb.pop_front();
        chk_eq("R5 R8 data order", int'(q), int'(last_rd));
      end
    end
  end

  task automatic do_reset(input bit two);
    rst_n = 1'b0;
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    wen2_ld = two;
    repeat (4) @(negedge rclk);
    chk_eq("R1 reset empty_n", int'(empty_n), 0);
    chk_eq("R1 reset aempty_n", int'(aempty_n), 0);
    chk_eq("R1 reset full_n", int'(full_n), 1);
    chk_eq("R1 reset afull_n", int'(afull_n), 1);
    chk_eq("R1 reset q", int'(q), 0);
    @(negedge wclk);
    rst_n = 1'b1;
    tb_two = two;
    sb.delete();
    last_rd = '0;
    pae_m = 7; paf_m = 7;
  endtask

  task automatic push(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen2_ld = 1'b1; wen1_n = 1'b0;
      din = DW'(base + i * 37);
      if (full_n) sb.push_back(din);
    end
    @(negedge wclk);
    wen1_n = 1'b1;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    @(negedge rclk);
    wen2_ld = 1'b1; ren1_n = 1'b0; ren2_n = 1'b0;
    while ((sb.size() > 0 || wr_busy) && guard < 2000) begin
      @(negedge rclk);
      guard++;
    end
    ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic check_flags(input string tag);
    int c;
    repeat (6) @(negedge rclk);
    c = sb.size();
    chk_eq({tag, " empty_n"}, int'(empty_n), int'(c != 0));
    chk_eq({tag, " aempty_n"}, int'(aempty_n), int'(c > pae_m));
    chk_eq({tag, " afull_n"}, int'(afull_n), int'(c < DEPTH - paf_m));
    chk_eq({tag, " full_n"}, int'(full_n), int'(c != DEPTH));
  endtask

  task automatic load_one(input int v);
    @(negedge wclk);
    wen2_ld = 1'b0; wen1_n = 1'b0; din = DW'(v);
    @(negedge wclk);
    wen1_n = 1'b1;
  endtask

  task automatic rb_expect(input string tag, input int exp);
    @(negedge rclk);
    wen2_ld = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
    @(posedge rclk);
    #2;
    chk_eq(tag, int'(q), exp);
  endtask

  task automatic rb_stop();
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // two-enable mode
    do_reset(1'b1);

    // R3: second enable low stores nothing
    @(negedge wclk);
    wen1_n = 1'b0; wen2_ld = 1'b0; din = 9'h55;
    repeat (3) @(negedge wclk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
    check_flags("R3 no write with wen2 low");

    // R6 and R7 boundaries with default offsets
    push(5, 10);  check_flags("R6 count5");
    push(2, 20);  check_flags("R6 count7");
    push(1, 30);  check_flags("R6 count8");
    push(1, 40);  check_flags("R6 count9");
    push(6, 50);  check_flags("R7 count15");
    push(3, 60);  check_flags("R7 R4 full with extra writes");

    // R5: one read enable alone reads nothing
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b1;
    repeat (3) @(negedge rclk);
    ren1_n = 1'b1;
    @(negedge rclk);
    ren2_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren2_n = 1'b1;
    check_flags("R5 single enable ignored");

    drain();
    check_flags("R7 drained");

    // R4: reads while empty leave q alone
    @(negedge rclk);
    ren1_n = 1'b0; ren2_n = 1'b0;
    repeat (3) @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    @(negedge rclk);
    chk_eq("R4 q after empty reads", int'(q), int'(last_rd));

    // R9: output enable
    oe_n = 1'b1; #1;
    chk_eq("R9 q_drv off", int'(q_drv), 0);
    chk_eq("R9 q zero", int'(q), 0);
    oe_n = 1'b0; #1;
    chk_eq("R9 q_drv on", int'(q_drv), 1);
    chk_eq("R9 q restored", int'(q), int'(last_rd));

    // R8: concurrent streaming across the clock domains
    wr_busy = 1'b1;
    fork
      begin push(40, 100); wr_busy = 1'b0; end
      drain();
    join
    check_flags("R8 after stream");

    // offset-program mode
    do_reset(1'b0);
    rb_expect("R11 default slot0", 7);
    rb_expect("R11 default slot1", 0);
    rb_expect("R11 default slot2", 7);
    rb_expect("R11 default slot3", 0);
    rb_stop();

    // R2 R10: loads, not writes
    load_one(3); load_one(0); load_one(2); load_one(0);
    pae_m = 3; paf_m = 2;
    check_flags("R2 R10 loads store no data");
    rb_expect("R10 slot0", 3);
    rb_expect("R10 slot1", 0);
    rb_expect("R10 slot2", 2);
    rb_expect("R10 slot3", 0);
    rb_stop();

    // R12 thresholds from loaded offsets (writes via wen1_n alone, R3)
    push(3, 200);  check_flags("R12 R3 count3");
    push(1, 210);  check_flags("R12 count4");
    push(9, 220);  check_flags("R12 count13");
    push(1, 230);  check_flags("R12 count14");

    // R11 read-back leaves the data
    rb_expect("R11 slot0 mid", 3);
    rb_stop();
    check_flags("R11 readback keeps count");

    // R10 wrap: fifth load goes to slot0
    load_one(5);
    pae_m = 5;
    rb_expect("R11 slot1", 0);
    rb_expect("R11 slot2", 2);
    rb_expect("R11 slot3", 0);
    rb_expect("R10 wrap slot0", 5);
    rb_stop();
    check_flags("R12 new threshold count14");

    drain();
    check_flags("R12 drained");

    // R11 R1: reset restores defaults and the rotation start
    do_reset(1'b0);
    rb_expect("R11 restart slot0", 7);
    rb_expect("R1 default slot1", 0);
    rb_expect("R1 default slot2", 7);
    rb_stop();

    summary();
  end
endmodule